// File: doc/BRIEF.md
# Serial Relay-Channel Control Slave

This block is the control front end of an eight-channel relay driver. A host reaches it over a four-wire serial link. While the select line is low, every rising edge of the serial clock moves one bit into a 16-bit shift register. The first byte of a frame is a register address and the second byte is the data, with the most significant address bit sent first. Nothing is written until the select line goes high again. At that point the block writes the captured data into the addressed register, but only when a whole number of frames was clocked in.

The block holds two registers. The channel register switches each relay channel on or off. The hold-mode register holds a 3-bit code. Code zero leaves the relays at full drive. The other seven codes choose a reduced hold level in 10% steps. The block presents that level as a percentage. For each channel that is on, it also raises a hold flag once a programmable number of system clocks has passed since the channel switched on, provided a reduced level is selected.

The last stage of the shift register drives the serial output on falling serial-clock edges, so several devices can share one select line in a chain. All serial inputs are first synchronised to the system clock.

Top module: `relay_spi_ctrl`

## Requirements
- R1: After reset, all channel outputs are 0, the level output is 100, every hold flag is 0 and the serial output is 0.
- R2: While select is low, each serial-clock rising edge shifts the data input into the shift register, first bit into the most significant position. Bits 15..8 form the address and bits 7..0 the data. No register changes before select rises.
- R3: On the select rising edge, the frame is written only if the number of clocked bits is a nonzero multiple of 16. Otherwise it is discarded. When 32 bits are clocked, the last 16 bits form the written frame.
- R4: A write to address 0x00 sets channel output N to data bit N, for N = 0..7.
- R5: A write to address 0x01 loads data bits 2..0 as the hold code. Data bits 7..3 have no effect.
- R6: A write to any address other than 0x00 and 0x01 leaves both registers unchanged.
- R7: The serial output is 0 while select is high. After each falling serial-clock edge it equals the input bit clocked 16 rising edges earlier within the same select-low period, or 0 while fewer than 16 bits have been clocked.
- R8: The level output is 100 for code 0 and 80 − 10 × code for codes 1..7 (70 down to 10).
- R9: Hold flag N rises exactly `hold_delay_i` system clocks after channel output N turns on, but only while the code is nonzero. It is 0 whenever the channel is off or the code is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk_i | input | 1 | Serial clock from host |
| spi_cs_n_i | input | 1 | Active-low select |
| spi_mosi_i | input | 1 | Serial data in |
| spi_miso_o | output | 1 | Serial data out for chaining |
| hold_delay_i | input | HOLD_W (16) | System clocks from channel-on to hold flag |
| chan_en_o | output | NUM_CH (8) | Channel enable lines |
| ps_pct_o | output | 7 | Selected drive level in percent |
| ps_hold_o | output | NUM_CH (8) | Per-channel reduced-hold flags |

## Verification
The assertions check on every cycle that registers change only on a commit and that writes to address 0x00 land exactly. They also check that foreign addresses leave both registers untouched, that the serial output stays quiet while the select line is high, that the level output stays on the 10% grid, and that a hold flag rises only for a channel already on. Only the bench scenarios can show the following:
- that partial and double-length frames are handled correctly;
- the exact 16-bit delay of the chained output;
- that the upper data bits are ignored by the hold-mode register;
- the exact number of clocks before a hold flag rises.

// File: rtl/relay_spi_pkg.sv
`timescale 1ns/1ps
package relay_spi_pkg;
    localparam int FRAME_W  = 16;
    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 8;
    localparam int CODE_W   = 3;
    localparam int PCT_W    = 7;

    localparam logic [ADDR_W-1:0] ADDR_CHAN = 8'h00;
    localparam logic [ADDR_W-1:0] ADDR_HOLD = 8'h01;

    // Drive level in percent selected by a hold-mode code
    function automatic logic [PCT_W-1:0] code_to_pct(input logic [CODE_W-1:0] code);
        if (code == '0) begin
            return PCT_W'(100);
        end
        return PCT_W'(80 - 10 * int'(code));
    endfunction
endpackage

// File: rtl/relay_spi_sync.sv
`timescale 1ns/1ps
module relay_spi_sync #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] lvl_o
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] pipe;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pipe[0] = raw_i;
        for (int i = 1; i < STAGES; i++) begin
            st_d.pipe[i] = st_q.pipe[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pipe <= {STAGES{RST_VAL}};
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl_o = st_q.pipe[STAGES-1];
endmodule

// File: rtl/relay_spi_shifter.sv
`timescale 1ns/1ps
module relay_spi_shifter
    import relay_spi_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_i,
    input  logic               cs_n_i,
    input  logic               mosi_i,
    output logic [FRAME_W-1:0] frame_o,
    output logic               commit_o,
    output logic               miso_o
);
    localparam int CNT_W = $clog2(FRAME_W);

    typedef struct packed {
        logic [FRAME_W-1:0] sh;
        logic [CNT_W-1:0]   cnt;
        logic               seen;
        logic               miso;
        logic               sclk_prev;
        logic               cs_prev;
    } shift_t;

    shift_t st_d, st_q;
    logic sclk_rise, sclk_fall, cs_rise, cs_fall;

    always_comb begin
        st_d      = st_q;
        sclk_rise = sclk_i & ~st_q.sclk_prev;
        sclk_fall = ~sclk_i & st_q.sclk_prev;
        cs_rise   = cs_n_i & ~st_q.cs_prev;
        cs_fall   = ~cs_n_i & st_q.cs_prev;
        commit_o  = cs_rise & st_q.seen & (st_q.cnt == '0);

        st_d.sclk_prev = sclk_i;
        st_d.cs_prev   = cs_n_i;

        if (cs_fall) begin
            st_d.sh   = '0;
            st_d.cnt  = '0;
            st_d.seen = 1'b0;
        end else if (!cs_n_i && sclk_rise) begin
            st_d.sh   = {st_q.sh[FRAME_W-2:0], mosi_i};
            st_d.cnt  = (st_q.cnt == CNT_W'(FRAME_W - 1)) ? '0 : st_q.cnt + 1'b1;
            st_d.seen = 1'b1;
        end

        if (cs_n_i) begin
            st_d.miso = 1'b0;
        end else if (sclk_fall) begin
            st_d.miso = st_q.sh[FRAME_W-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.sclk_prev <= 1'b0;
            st_q.cs_prev   <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign frame_o = st_q.sh;
    assign miso_o  = st_q.miso;

    AST_MISO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_i && st_q.cs_prev) |=> !miso_o); // R7
endmodule

// File: rtl/relay_spi_regs.sv
`timescale 1ns/1ps
module relay_spi_regs
    import relay_spi_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               commit_i,
    input  logic [FRAME_W-1:0] frame_i,
    output logic [NUM_CH-1:0]  chan_o,
    output logic [CODE_W-1:0]  code_o
);
    typedef struct packed {
        logic [NUM_CH-1:0] chan;
        logic [CODE_W-1:0] code;
    } regs_t;

    regs_t st_d, st_q;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;

    assign addr = frame_i[FRAME_W-1 -: ADDR_W];
    assign data = frame_i[DATA_W-1:0];

    always_comb begin
        st_d = st_q;
        if (commit_i) begin
            unique case (addr)
                ADDR_CHAN: st_d.chan = data[NUM_CH-1:0];
                ADDR_HOLD: st_d.code = data[CODE_W-1:0];
                default:   st_d      = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign chan_o = st_q.chan;
    assign code_o = st_q.code;

    AST_WRITE_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && frame_i[FRAME_W-1 -: ADDR_W] == ADDR_CHAN)
        |=> chan_o == $past(frame_i[NUM_CH-1:0])); // R4
    AST_IGNORE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && frame_i[FRAME_W-1 -: ADDR_W] != ADDR_CHAN
                  && frame_i[FRAME_W-1 -: ADDR_W] != ADDR_HOLD)
        |=> ($stable(chan_o) && $stable(code_o))); // R6
    AST_HOLD_UNTIL_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> ($stable(chan_o) && $stable(code_o))); // R3
endmodule

// File: rtl/relay_spi_hold.sv
`timescale 1ns/1ps
module relay_spi_hold
    import relay_spi_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int HOLD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] chan_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [HOLD_W-1:0] delay_i,
    output logic [NUM_CH-1:0] active_o
);
    typedef struct packed {
        logic [NUM_CH-1:0][HOLD_W-1:0] cnt;
    } hold_t;

    hold_t st_d, st_q;
    logic  save_en;

    assign save_en = (code_i != '0);

    always_comb begin
        st_d = st_q;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            if (chan_i[ch] && save_en) begin
                st_d.cnt[ch] = (st_q.cnt[ch] >= delay_i) ? st_q.cnt[ch]
                                                          : st_q.cnt[ch] + 1'b1;
            end else begin
                st_d.cnt[ch] = '0;
            end
            active_o[ch] = chan_i[ch] && save_en && (st_q.cnt[ch] >= delay_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        AST_HOLD_AFTER_ON: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(active_o[g]) && delay_i != '0) |-> $past(chan_i[g])); // R9
    end
endmodule

// File: rtl/relay_spi_ctrl.sv
`timescale 1ns/1ps
module relay_spi_ctrl
    import relay_spi_pkg::*;
#(
    parameter int NUM_CH      = 8,
    parameter int HOLD_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk_i,
    input  logic              spi_cs_n_i,
    input  logic              spi_mosi_i,
    output logic              spi_miso_o,
    input  logic [HOLD_W-1:0] hold_delay_i,
    output logic [NUM_CH-1:0] chan_en_o,
    output logic [PCT_W-1:0]  ps_pct_o,
    output logic [NUM_CH-1:0] ps_hold_o
);
    localparam int SYNC_W = 3;

    logic [SYNC_W-1:0]  raw, lvl;
    logic [FRAME_W-1:0] frame;
    logic               commit;
    logic [CODE_W-1:0]  code;

    assign raw = {spi_mosi_i, spi_cs_n_i, spi_sclk_i};

    relay_spi_sync #(
        .W       (SYNC_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b010)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_i (raw),
        .lvl_o (lvl)
    );

    relay_spi_shifter u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_i   (lvl[0]),
        .cs_n_i   (lvl[1]),
        .mosi_i   (lvl[2]),
        .frame_o  (frame),
        .commit_o (commit),
        .miso_o   (spi_miso_o)
    );

    relay_spi_regs #(.NUM_CH(NUM_CH)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (commit),
        .frame_i  (frame),
        .chan_o   (chan_en_o),
        .code_o   (code)
    );

    relay_spi_hold #(.NUM_CH(NUM_CH), .HOLD_W(HOLD_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .chan_i   (chan_en_o),
        .code_i   (code),
        .delay_i  (hold_delay_i),
        .active_o (ps_hold_o)
    );

    assign ps_pct_o = code_to_pct(code);

    AST_PCT_GRID: assert property (@(posedge clk) disable iff (!rst_n)
        (ps_pct_o >= 7'd10) && (ps_pct_o <= 7'd100) && (ps_pct_o % 7'd10 == 7'd0)); // R8
endmodule

// File: tb/relay_spi_ctrl_bench.sv
`timescale 1ns/1ps
module relay_spi_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        cs_n = 1'b1;
    logic        mosi = 1'b0;
    logic        miso;
    logic [15:0] hold_delay = 16'd6;
    logic [7:0]  chan;
    logic [6:0]  pct;
    logic [7:0]  hold;

    int checks = 0;
    int errors = 0;
    logic [31:0] cap;

    always #2.5 clk = ~clk;

    relay_spi_ctrl u_relay_spi_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .spi_sclk_i   (sclk),
        .spi_cs_n_i   (cs_n),
        .spi_mosi_i   (mosi),
        .spi_miso_o   (miso),
        .hold_delay_i (hold_delay),
        .chan_en_o    (chan),
        .ps_pct_o     (pct),
        .ps_hold_o    (hold)
    );

    // {address, data, expected channels, expected percent}
    localparam logic [31:0] VEC [8] = '{
        {8'h00, 8'hA5, 8'hA5, 8'd100},   // R4
        {8'h01, 8'h03, 8'hA5, 8'd50},    // R5 R8
        {8'h01, 8'hF7, 8'hA5, 8'd10},    // R5 upper bits ignored
        {8'h05, 8'hFF, 8'hA5, 8'd10},    // R6
        {8'h00, 8'h3C, 8'h3C, 8'd10},    // R4
        {8'h01, 8'h00, 8'h3C, 8'd100},   // R8
        {8'h81, 8'h02, 8'h3C, 8'd100},   // R6
        {8'h01, 8'h01, 8'h3C, 8'd70}     // R8
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Clock n bits of word out, first bit word[n-1]; miso captured after each fall
    task automatic send(input logic [31:0] word, input int n);
        @(negedge clk);
        cs_n = 1'b0;
        wait_clk(8);
        for (int i = 0; i < n; i++) begin
            mosi = word[n-1-i];
            wait_clk(8);
            sclk = 1'b1;
            wait_clk(8);
            sclk = 1'b0;
            wait_clk(8);
            cap[i] = miso;
        end
    endtask

    task automatic release_cs();
        @(negedge clk);
        cs_n = 1'b1;
    endtask

    task automatic frame(input logic [31:0] word, input int n);
        send(word, n);
        release_cs();
        wait_clk(10);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wait_clk(4);
        // R1 reset state
        check("R1 chan", chan, 0);
        check("R1 pct", pct, 100);
        check("R1 hold", hold, 0);
        check("R1 miso", miso, 0);
        rst_n = 1'b1;
        wait_clk(4);

        for (int v = 0; v < 8; v++) begin
            frame({16'h0, VEC[v][31:16]}, 16);
            check($sformatf("R4/R6 vec%0d chan", v), chan, VEC[v][15:8]);
            check($sformatf("R5/R8 vec%0d pct", v), pct, VEC[v][7:0]);
        end

        // R2: nothing written while select still low
        send({16'h0, 16'h00FF}, 16);
        wait_clk(10);
        check("R2 no write before select rise", chan, 8'h3C);
        release_cs();
        wait_clk(10);
        check("R2 write on select rise", chan, 8'hFF);

        // R3: partial frames discarded
        frame({20'h0, 12'h000}, 12);
        check("R3 12-bit frame discarded", chan, 8'hFF);
        frame({12'h0, 20'h00000}, 20);
        check("R3 20-bit frame discarded", chan, 8'hFF);

        // R3/R7: 32-bit frame, last 16 bits win, miso is delayed 16 clocks
        send(32'h0011_0022, 32);
        check("R7 miso zero in first 15 bits", cap[14:0], 15'h0);
        for (int i = 15; i < 31; i++) begin
            check($sformatf("R7 miso bit %0d", i), cap[i], (32'h0011_0022 >> (31 - (i - 15))) & 1);
        end
        release_cs();
        wait_clk(10);
        check("R3 32-bit frame uses last 16", chan, 8'h22);
        check("R7 miso quiet with select high", miso, 0);

        // R9 hold timing
        frame({16'h0, 16'h0000}, 16);
        frame({16'h0, 16'h0102}, 16);
        check("R8 code 2", pct, 60);
        send({16'h0, 16'h0001}, 16);
        release_cs();
        begin
            int waited = 0;
            int cnt = 0;
            while (!chan[0] && waited < 100) begin
                @(negedge clk);
                waited++;
            end
            while (!hold[0] && cnt < 200) begin
                @(negedge clk);
                cnt++;
            end
            check("R9 hold delay cycles", cnt, 6);
        end
        wait_clk(10);
        check("R9 hold only on active channel", hold, 8'h01);
        frame({16'h0, 16'h0100}, 16);
        check("R9 code 0 clears hold", hold, 8'h00);
        wait_clk(30);
        check("R9 code 0 keeps hold low", hold, 8'h00);
        frame({16'h0, 16'h0105}, 16);
        wait_clk(20);
        check("R9 hold returns", hold, 8'h01);
        frame({16'h0, 16'h0000}, 16);
        check("R9 channel off clears hold", hold, 8'h00);

        // R1 reset mid-run
        frame({16'h0, 16'h00C3}, 16);
        @(negedge clk);
        rst_n = 1'b0;
        wait_clk(3);
        check("R1 reset chan", chan, 0);
        check("R1 reset pct", pct, 100);
        rst_n = 1'b1;
        wait_clk(3);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule